// File: doc/BRIEF.md
# IOTLB Invalidation Request Register

This block is a single 64-bit memory-mapped control register through which software asks for an I/O translation cache to be invalidated. A write that enables the most significant byte and carries a 1 in bit 63 captures the requested granularity and domain-id, marks the register busy, and hands the request to a small sequencer. When the platform capability input says so, the sequencer first runs a write-buffer flush handshake. It then raises an invalidation request toward the engine and holds it until the engine reports done.

On completion the busy bit clears by itself, and the granularity that was actually carried out is posted in a separate read-only field. A configuration input lets page-selective requests be carried out as domain-selective ones, which exercises the coarsening and reporting path. A request with the reserved granularity code is never passed to the engine. It retires on the next cycle and reports code 00. While the register is busy, every write to it is dropped.

Top module: `iotlb_inv_reg`

## Requirements
- R1: After a synchronous reset the register reads 0x0200_0000_0000_0000 (actual granularity 01, all else 0), and wbf_req and inv_req are low.
- R2: A request starts only on a write to offset 0x108 with byte enable 7 set and wdata bit 63 equal to 1. A write without byte 7 enabled, or to another offset, starts nothing.
- R3: Bits 62, 59, 56:48 and 31:0 always read 0, whatever is written.
- R4: When idle, byte 7 writes the requested granularity (bits 61:60), bytes 4 and 5 write the domain-id (bits 47:32), and the actual granularity (bits 58:57) is unaffected by writes.
- R5: With flush_cap = 1, wbf_req rises in the cycle after the start write, and inv_req stays low until wbf_ack has been seen. inv_req rises in the cycle after the ack, and wbf_req falls in that same cycle.
- R6: With flush_cap = 0, inv_req rises in the cycle after the start write, and wbf_req stays low.
- R7: inv_req, inv_gran and inv_did hold steady until inv_done. In the cycle after inv_done, inv_req is low, bit 63 is 0, and bits 58:57 hold the performed granularity. inv_req and wbf_req are never high while bit 63 is 0.
- R8: A page-selective request (code 11) is performed as domain-selective (code 10) when coarsen_page = 1; otherwise the performed code equals the requested one (01 global, 10 domain, 11 page). The performed code appears on inv_gran.
- R9: A request with code 00 raises neither wbf_req nor inv_req. Bit 63 clears one cycle after the start write, and bits 58:57 then read 00.
- R10: Any write while bit 63 is 1 changes neither the granularity, the domain-id nor bit 63, and starts no new request.
- R11: Bit 63 reads 1 from the cycle after the start write until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_be | input | 8 | Write byte enables |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Register contents |
| flush_cap | input | 1 | Write-buffer flush required before invalidation |
| coarsen_page | input | 1 | Perform page-selective requests as domain-selective |
| wbf_req | output | 1 | Write-buffer flush request |
| wbf_ack | input | 1 | Write-buffer flush complete |
| inv_req | output | 1 | Invalidation request to the engine |
| inv_gran | output | 2 | Granularity to perform |
| inv_did | output | DID_W | Domain-id for the request |
| inv_done | input | 1 | Engine finished the invalidation |

## Verification
The bench builds the block with its defaults: a 12-bit offset, offset 0x108 and a 16-bit domain-id. With these values every bit of the 64-bit word is defined, and both domain-id bytes can be hit with partial byte enables. Random requests vary flush_cap, coarsen_page and the ack and done delays, so that flush-then-issue, direct issue, coarsening and reserved-code retirement all occur. Random byte-enabled writes go to the register and to a neighbouring offset, and some land while the register is busy.

// File: rtl/iotlb_inv_pkg.sv
package iotlb_inv_pkg;
  typedef enum logic [1:0] {
    GR_RSVD   = 2'b00,
    GR_GLOBAL = 2'b01,
    GR_DOMAIN = 2'b10,
    GR_PAGE   = 2'b11
  } gran_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FLUSH,
    SQ_ISSUE,
    SQ_RSVD
  } seq_e;

  localparam int BUSY_BIT = 63;
  localparam int REQG_LSB = 60;
  localparam int ACTG_LSB = 57;
  localparam int DID_LSB  = 32;
  localparam int DID_BYTE = 4;
  localparam int TOP_BYTE = 7;
endpackage

// File: rtl/iotlb_inv_fields.sv
module iotlb_inv_fields
  import iotlb_inv_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFFSET = 'h108,
  parameter int DID_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_be,
  input  logic [63:0]       reg_wdata,
  input  logic              seq_done,
  input  logic [1:0]        seq_gran,
  output logic              busy_q,
  output logic [1:0]        reqg_q,
  output logic [1:0]        actg_q,
  output logic [DID_W-1:0]  did_q,
  output logic              start,
  output logic [1:0]        start_gran,
  output logic [DID_W-1:0]  start_did
);
  localparam int DID_BYTES = DID_W / 8;
  localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'(OFFSET);

  logic             wr_ok;
  logic [1:0]       reqg_n;
  logic [DID_W-1:0] did_n;
  logic             unused_bits;

  assign unused_bits = ^{reg_wdata, reg_be};
  assign wr_ok = reg_wr && (reg_addr == OFF_A) && !busy_q;
  assign reqg_n = (wr_ok && reg_be[TOP_BYTE]) ? reg_wdata[REQG_LSB +: 2] : reqg_q;
  assign start = wr_ok && reg_be[TOP_BYTE] && reg_wdata[BUSY_BIT];
  assign start_gran = reqg_n;
  assign start_did = did_n;

  always_comb begin
    did_n = did_q;
    for (int b = 0; b < DID_BYTES; b++) begin
      if (wr_ok && reg_be[DID_BYTE + b])
        did_n[b*8 +: 8] = reg_wdata[DID_LSB + b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      reqg_q <= GR_RSVD;
      actg_q <= GR_GLOBAL;
      did_q  <= '0;
    end else begin
      reqg_q <= reqg_n;
      did_q  <= did_n;
      if (start)
        busy_q <= 1'b1;
      else if (seq_done)
        busy_q <= 1'b0;
      if (seq_done)
        actg_q <= seq_gran;
    end
  end

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(did_q) && $stable(reqg_q))
    else $error("R10 fields changed while busy");

  p_busy_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(seq_done))
    else $error("R11 busy cleared without completion");
endmodule

// File: rtl/iotlb_inv_seq.sv
module iotlb_inv_seq
  import iotlb_inv_pkg::*;
#(
  parameter int DID_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       start_gran,
  input  logic [DID_W-1:0] start_did,
  input  logic             flush_cap,
  input  logic             coarsen_page,
  input  logic             wbf_ack,
  input  logic             inv_done,
  output logic             wbf_req_q,
  output logic             inv_req_q,
  output logic [1:0]       inv_gran_q,
  output logic [DID_W-1:0] inv_did_q,
  output logic             done
);
  seq_e       state_q;
  logic [1:0] perf_gran;

  assign perf_gran = (start_gran == GR_PAGE && coarsen_page) ? GR_DOMAIN : start_gran;
  assign done = (state_q == SQ_RSVD) || (state_q == SQ_ISSUE && inv_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      wbf_req_q  <= 1'b0;
      inv_req_q  <= 1'b0;
      inv_gran_q <= GR_RSVD;
      inv_did_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          inv_did_q  <= start_did;
          inv_gran_q <= perf_gran;
          if (start_gran == GR_RSVD) begin
            state_q <= SQ_RSVD;
          end else if (flush_cap) begin
            state_q   <= SQ_FLUSH;
            wbf_req_q <= 1'b1;
          end else begin
            state_q   <= SQ_ISSUE;
            inv_req_q <= 1'b1;
          end
        end
        SQ_FLUSH: if (wbf_ack) begin
          wbf_req_q <= 1'b0;
          inv_req_q <= 1'b1;
          state_q   <= SQ_ISSUE;
        end
        SQ_ISSUE: if (inv_done) begin
          inv_req_q <= 1'b0;
          state_q   <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(wbf_req_q && inv_req_q))
    else $error("R5 flush and invalidation overlap");

  p_flush_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(inv_req_q) && flush_cap |-> $past(wbf_req_q) && $past(wbf_ack))
    else $error("R5 invalidation issued before flush ack");

  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    inv_req_q && !inv_done |=> inv_req_q && $stable(inv_gran_q) && $stable(inv_did_q))
    else $error("R7 request dropped or changed before done");

  p_no_rsvd_issue_r9: assert property (@(posedge clk) disable iff (rst)
    inv_req_q |-> inv_gran_q != GR_RSVD)
    else $error("R9 reserved code sent to engine");
endmodule

// File: rtl/iotlb_inv_reg.sv
module iotlb_inv_reg
  import iotlb_inv_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFFSET = 'h108,
  parameter int DID_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_be,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              flush_cap,
  input  logic              coarsen_page,
  output logic              wbf_req,
  input  logic              wbf_ack,
  output logic              inv_req,
  output logic [1:0]        inv_gran,
  output logic [DID_W-1:0]  inv_did,
  input  logic              inv_done
);
  logic             busy_q;
  logic [1:0]       reqg_q;
  logic [1:0]       actg_q;
  logic [DID_W-1:0] did_q;
  logic             start;
  logic [1:0]       start_gran;
  logic [DID_W-1:0] start_did;
  logic             seq_done;

  iotlb_inv_fields #(.ADDR_W(ADDR_W), .OFFSET(OFFSET), .DID_W(DID_W)) u_fields (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_be     (reg_be),
    .reg_wdata  (reg_wdata),
    .seq_done   (seq_done),
    .seq_gran   (inv_gran),
    .busy_q     (busy_q),
    .reqg_q     (reqg_q),
    .actg_q     (actg_q),
    .did_q      (did_q),
    .start      (start),
    .start_gran (start_gran),
    .start_did  (start_did)
  );

  iotlb_inv_seq #(.DID_W(DID_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_gran   (start_gran),
    .start_did    (start_did),
    .flush_cap    (flush_cap),
    .coarsen_page (coarsen_page),
    .wbf_ack      (wbf_ack),
    .inv_done     (inv_done),
    .wbf_req_q    (wbf_req),
    .inv_req_q    (inv_req),
    .inv_gran_q   (inv_gran),
    .inv_did_q    (inv_did),
    .done         (seq_done)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[BUSY_BIT]          = busy_q;
    reg_rdata[REQG_LSB +: 2]     = reqg_q;
    reg_rdata[ACTG_LSB +: 2]     = actg_q;
    reg_rdata[DID_LSB +: DID_W]  = did_q;
  end

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !wbf_req && !inv_req)
    else $error("R7 handshake active while not busy");
endmodule

// File: tb/test_iotlb_inv_reg.sv
module test_iotlb_inv_reg;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int OFF    = 'h108;
  localparam int DID_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0]        reg_be = '0;
  logic [63:0]       reg_wdata = '0;
  logic [63:0]       reg_rdata;
  logic              flush_cap = 1'b0;
  logic              coarsen_page = 1'b0;
  logic              wbf_req;
  logic              wbf_ack = 1'b0;
  logic              inv_req;
  logic [1:0]        inv_gran;
  logic [DID_W-1:0]  inv_did;
  logic              inv_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  logic             m_busy = 1'b0;
  logic [1:0]       m_reqg = 2'b00;
  logic [1:0]       m_actg = 2'b01;
  logic [15:0]      m_did  = '0;

  always #(CLK_P/2) clk = ~clk;

  iotlb_inv_reg #(.ADDR_W(ADDR_W), .OFFSET(OFF), .DID_W(DID_W)) i_iotlb_inv_reg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flush_cap(flush_cap),
    .coarsen_page(coarsen_page), .wbf_req(wbf_req), .wbf_ack(wbf_ack),
    .inv_req(inv_req), .inv_gran(inv_gran), .inv_did(inv_did), .inv_done(inv_done)
  );

  function automatic logic [63:0] exp_word();
    logic [63:0] w = '0;
    w[63] = m_busy;
    w[61:60] = m_reqg;
    w[58:57] = m_actg;
    w[47:32] = m_did;
    return w;
  endfunction

  function automatic logic [1:0] perf_of(logic [1:0] g, logic c);
    return (g == 2'b11 && c) ? 2'b10 : g;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] be, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_be = '0;
    if (a == ADDR_W'(OFF) && !m_busy) begin
      if (be[7]) m_reqg = d[61:60];
      if (be[4]) m_did[7:0] = d[39:32];
      if (be[5]) m_did[15:8] = d[47:40];
      if (be[7] && d[63]) m_busy = 1'b1;
    end
  endtask

  task automatic run_req(logic [1:0] g, logic [15:0] did, logic cap, logic coar,
                         int ack_dly, int done_dly, logic poke);
    logic [63:0] d = '0;
    logic [1:0]  pg = perf_of(g, coar);
    flush_cap = cap; coarsen_page = coar;
    d[63] = 1'b1; d[61:60] = g; d[47:32] = did;
    wr(ADDR_W'(OFF), 8'hB0, d);
    chk("R11 busy after start", reg_rdata, exp_word());
    if (g == 2'b00) begin
      chk("R9 no requests", {62'd0, wbf_req, inv_req}, 64'd0);
      cyc();
      m_busy = 1'b0; m_actg = 2'b00;
      chk("R9 retire word", reg_rdata, exp_word());
      return;
    end
    if (cap) begin
      chk("R5 flush first", {62'd0, wbf_req, inv_req}, 64'd2);
      for (int i = 0; i < ack_dly; i++) begin
        cyc();
        chk("R5 wait ack", {62'd0, wbf_req, inv_req}, 64'd2);
      end
      wbf_ack = 1'b1;
      cyc();
      wbf_ack = 1'b0;
    end else begin
      chk("R6 no flush", {63'd0, wbf_req}, 64'd0);
    end
    chk("R7 req issued", {62'd0, wbf_req, inv_req}, 64'd1);
    chk("R8 gran", {62'd0, inv_gran}, {62'd0, pg});
    chk("R7 did", {48'd0, inv_did}, {48'd0, did});
    for (int i = 0; i < done_dly; i++) cyc();
    if (poke) begin
      wr(ADDR_W'(OFF), 8'hFF, {$urandom, $urandom} | 64'h8000_0000_0000_0000);
      chk("R10 busy write ignored", reg_rdata, exp_word());
      chk("R10 req held", {63'd0, inv_req}, 64'd1);
    end
    inv_done = 1'b1;
    cyc();
    inv_done = 1'b0;
    m_busy = 1'b0; m_actg = pg;
    chk("R7 completion word", reg_rdata, exp_word());
    chk("R7 req low", {62'd0, wbf_req, inv_req}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset word", reg_rdata, 64'h0200_0000_0000_0000);
    chk("R1 reset reqs", {62'd0, wbf_req, inv_req}, 64'd0);

    wr(ADDR_W'(OFF), 8'h7F, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 no start without top byte", reg_rdata, exp_word());
    chk("R3 reserved zero", reg_rdata & 64'h4000_0000_0000_0000, 64'd0);
    cyc();
    chk("R2 no req", {62'd0, wbf_req, inv_req}, 64'd0);
    wr(ADDR_W'(OFF + 8), 8'hFF, 64'hB000_1234_0000_0000);
    chk("R2 other offset", reg_rdata, exp_word());
    wr(ADDR_W'(OFF), 8'h80, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R4 gran written, actual untouched", reg_rdata, exp_word());
    chk("R3 reserved bits", reg_rdata & 64'h49FF_0000_FFFF_FFFF, 64'd0);

    run_req(2'b01, 16'hA5A5, 1'b1, 1'b0, 0, 0, 1'b0);
    run_req(2'b10, 16'h1234, 1'b0, 1'b0, 0, 2, 1'b1);
    run_req(2'b11, 16'h00FF, 1'b0, 1'b1, 0, 1, 1'b0);
    run_req(2'b11, 16'hBEEF, 1'b1, 1'b0, 3, 0, 1'b1);
    run_req(2'b00, 16'h0F0F, 1'b1, 1'b0, 0, 0, 1'b0);
    run_req(2'b11, 16'hC0DE, 1'b1, 1'b1, 2, 3, 1'b1);

    for (int it = 0; it < 80; it++) begin
      if ($urandom % 2 == 0) begin
        logic [63:0] d = {$urandom, $urandom};
        logic [ADDR_W-1:0] a = ($urandom % 4 == 0) ? ADDR_W'(OFF + 8) : ADDR_W'(OFF);
        logic [7:0] be = 8'($urandom);
        d[63] = 1'b0;
        wr(a, be, d);
        chk("R4 random write", reg_rdata, exp_word());
        chk("R3 random reserved", reg_rdata & 64'h49FF_0000_FFFF_FFFF, 64'd0);
      end else begin
        run_req(2'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 4), int'($urandom % 4), 1'($urandom));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule